// File: doc/BRIEF.md
# Periodic Interrupt and Square-Wave Rate Selector

This block divides a 32.768 kHz time base through a 15-stage binary counter and uses a 4-bit rate code to pick one divider stage. The time base arrives as a one-cycle enable, `tick_i`, in the system clock domain. The chosen stage level appears directly on a square-wave output. Each time the chosen stage completes a full period, a one-cycle periodic pulse is raised. The final stage produces a one-second tick for a calendar counter, and this tick does not depend on the rate code.

The rate code is not a linear index. Code 0 turns the selector off. Codes 3 to 7 cover the fast range from 8.192 kHz down to 512 Hz. Codes 8 to 15 cover 256 Hz down to 2 Hz. Codes 1 and 2 repeat the 256 Hz and 128 Hz settings. The square-wave output can be gated off by an enable bit and by a power-fail input. The periodic pulse can be gated off by its own enable. A synchronous divider clear holds every stage at zero.

Top module: `rtc_pi_sqw_sel`

## Requirements
- R1: While `rst_ni` is low, `sqw_o`, `pi_flag_o` and `sec_tick_o` are all 0.
- R2: The divider advances by one only on clock edges where `tick_i` is 1. While `div_clr_i` is 1, the divider is held at zero, so `sqw_o` and both pulses stay 0. After release, counting restarts from zero.
- R3: With rate code 0, `sqw_o` stays 0 and `pi_flag_o` never pulses.
- R4: Codes 3, 4, 5, 6 and 7 select divider bits 1, 2, 3, 4 and 5 (8192, 4096, 2048, 1024 and 512 Hz). With enables on, `sqw_o` equals that bit of the tick count since release.
- R5: Codes 1 and 8 both select bit 6 (256 Hz). Codes 2 and 9 both select bit 7 (128 Hz).
- R6: Codes 10 to 15 select bits 8 to 13 (64, 32, 16, 8, 4 and 2 Hz). Code 15 gives a 16384-tick (500 ms) period.
- R7: For a nonzero code selecting bit k, with `pi_en_i` at 1, `pi_flag_o` is 1 for exactly one cycle after each tick that makes the tick count a multiple of 2^(k+1).
- R8: `sqw_o` is 0 whenever `sqw_en_i` is 0 or `pwr_fail_i` is 1.
- R9: When `pi_en_i` was 0 at an edge, `pi_flag_o` is 0 in the following cycle.
- R10: `sec_tick_o` is 1 for one cycle after every 32768th tick, whatever the rate code. The first pulse follows the 32768th tick after a divider clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable, one cycle per 32.768 kHz period |
| rate_sel_i | input | 4 | Rate code |
| sqw_en_i | input | 1 | Square-wave output enable |
| pi_en_i | input | 1 | Periodic pulse enable |
| pwr_fail_i | input | 1 | Power-fail, forces square wave low |
| div_clr_i | input | 1 | Synchronous divider clear |
| sqw_o | output | 1 | Square-wave output |
| pi_flag_o | output | 1 | Periodic pulse, one cycle |
| sec_tick_o | output | 1 | One-second pulse, one cycle |

## Verification
A wrong divider bit or a wrong code-to-stage mapping shows up on `sqw_o` at the first tick where the chosen bit and the intended bit differ. For fast codes that happens within two ticks. For the 2 Hz code it can take up to 8192 ticks. A periodic pulse at the wrong phase shows up at the first multiple of the period. A fault in the final stage only becomes visible after 32768 ticks, when `sec_tick_o` is due. Gating faults show up as soon as an enable or the power-fail input changes.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;
  localparam int unsigned TAP_W = 4;

  // rate code -> divider bit; code 0 is unused (off)
  function automatic logic [TAP_W-1:0] rate_tap(input logic [3:0] code);
    logic [TAP_W-1:0] t;
    if (code == 4'd0)      t = '0;
    else if (code < 4'd3)  t = TAP_W'(code + 4'd5);
    else                   t = TAP_W'(code - 4'd2);
    return t;
  endfunction
endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
  parameter int unsigned DIV_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] ones_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // ones_o[k]: bits k..0 all set, so the next tick wraps stage k
  assign ones_o[0] = cnt_q[0];
  for (genvar g = 1; g < DIV_W; g++) begin : g_ones
    assign ones_o[g] = ones_o[g-1] & cnt_q[g];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_tap_sel.sv
module rtc_tap_sel
  import rtc_div_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic [DIV_W-1:0] cnt_i,
  input  logic [DIV_W-1:0] ones_i,
  input  logic [3:0]       code_i,
  output logic             active_o,
  output logic             lvl_o,
  output logic             wrap_o
);
  logic [TAP_W-1:0] tap;

  assign tap      = rate_tap(code_i);
  assign active_o = (code_i != 4'd0);

  always_comb begin
    lvl_o  = 1'b0;
    wrap_o = 1'b0;
    for (int i = 0; i < DIV_W; i++) begin
      if (32'(tap) == i) begin
        lvl_o  = cnt_i[i];
        wrap_o = ones_i[i];
      end
    end
  end
endmodule

// File: rtl/rtc_pi_sqw_sel.sv
module rtc_pi_sqw_sel #(
  parameter int unsigned DIV_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [3:0] rate_sel_i,
  input  logic       sqw_en_i,
  input  logic       pi_en_i,
  input  logic       pwr_fail_i,
  input  logic       div_clr_i,
  output logic       sqw_o,
  output logic       pi_flag_o,
  output logic       sec_tick_o
);
  localparam int unsigned SEC_BIT = DIV_W - 1;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] ones;
  logic             active, lvl, wrap;
  logic             pi_q, sec_q;

  rtc_div_chain #(.DIV_W(DIV_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (div_clr_i),
    .cnt_o  (cnt),
    .ones_o (ones)
  );

  rtc_tap_sel #(.DIV_W(DIV_W)) u_sel (
    .cnt_i    (cnt),
    .ones_i   (ones),
    .code_i   (rate_sel_i),
    .active_o (active),
    .lvl_o    (lvl),
    .wrap_o   (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pi_q  <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      pi_q  <= tick_i & ~div_clr_i & active & pi_en_i & wrap;
      sec_q <= tick_i & ~div_clr_i & ones[SEC_BIT];
    end
  end

  assign sqw_o      = sqw_en_i & ~pwr_fail_i & active & lvl;
  assign pi_flag_o  = pi_q;
  assign sec_tick_o = sec_q;
endmodule

// File: rtl/rtc_pi_sqw_sel_chk.sv
module rtc_pi_sqw_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [3:0] rate_sel_i,
  input logic       sqw_en_i,
  input logic       pi_en_i,
  input logic       pwr_fail_i,
  input logic       div_clr_i,
  input logic       sqw_o,
  input logic       pi_flag_o,
  input logic       sec_tick_o
);
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!pi_flag_o && !sec_tick_o);
    end
  end

  a_r2_clr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(div_clr_i) |-> (!pi_flag_o && !sec_tick_o));

  a_r2_no_tick_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> (!pi_flag_o && !sec_tick_o));

  a_r3_code0_no_sqw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i == 4'd0) |-> !sqw_o);

  a_r3_code0_no_pi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rate_sel_i) == 4'd0) |-> !pi_flag_o);

  a_r7_pi_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pi_flag_o |=> !pi_flag_o);

  a_r8_sqw_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sqw_en_i || pwr_fail_i) |-> !sqw_o);

  a_r9_pi_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pi_en_i) |-> !pi_flag_o);

  a_r10_sec_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);
endmodule

bind rtc_pi_sqw_sel rtc_pi_sqw_sel_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .rate_sel_i (rate_sel_i),
  .sqw_en_i   (sqw_en_i),
  .pi_en_i    (pi_en_i),
  .pwr_fail_i (pwr_fail_i),
  .div_clr_i  (div_clr_i),
  .sqw_o      (sqw_o),
  .pi_flag_o  (pi_flag_o),
  .sec_tick_o (sec_tick_o)
);

// File: tb/rtc_pi_sqw_sel_bench.sv
module rtc_pi_sqw_sel_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] code = 4'd0;
  logic       sqw_en = 1'b1;
  logic       pi_en = 1'b1;
  logic       pwr_fail = 1'b0;
  logic       div_clr = 1'b0;
  logic       sqw, pi_flag, sec_tick;

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rtc_pi_sqw_sel u_rtc_pi_sqw_sel (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .rate_sel_i (code),
    .sqw_en_i   (sqw_en),
    .pi_en_i    (pi_en),
    .pwr_fail_i (pwr_fail),
    .div_clr_i  (div_clr),
    .sqw_o      (sqw),
    .pi_flag_o  (pi_flag),
    .sec_tick_o (sec_tick)
  );

  // frequency in Hz for each nonzero rate code
  function automatic int freq_of(input int c);
    if (c == 1 || c == 2) return 512 >> c;
    if (c <= 7)           return 8192 >> (c - 3);
    return 256 >> (c - 8);
  endfunction

  function automatic string req_of(input int c);
    if (c == 0) return "R3";
    if (c >= 3 && c <= 7) return "R4";
    if (c <= 9) return "R5";
    return "R6";
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: n=%0d code=%0d actual=%0b expected=%0b", req, what, n, code, act, exp);
    end
  endtask

  task automatic step(input logic en);
    tick = en;
    @(posedge clk);
    if (en && !div_clr) n++;
    @(negedge clk);
  endtask

  // one step then compare all three outputs against the tick count
  task automatic step_chk(input logic en);
    int per;
    logic e_sqw, e_pi, e_sec;
    step(en);
    per = (code == 0) ? 1 : 32768 / freq_of(int'(code));
    e_sqw = (code != 0) && sqw_en && !pwr_fail && (((n / (per / 2)) % 2) == 1);
    e_pi  = en && (code != 0) && pi_en && (n > 0) && ((n % per) == 0);
    e_sec = en && (n > 0) && ((n % 32768) == 0);
    chk(sqw, e_sqw, (!sqw_en || pwr_fail) ? "R8" : req_of(int'(code)), "sqw");
    chk(pi_flag, e_pi, (code == 0) ? "R3" : (pi_en ? "R7" : "R9"), "pi_flag");
    chk(sec_tick, e_sec, "R10", "sec_tick");
  endtask

  task automatic restart();
    div_clr = 1'b1;
    step(1'b0);
    div_clr = 1'b0;
    n = 0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk(sqw, 1'b0, "R1", "sqw in reset");
    chk(pi_flag, 1'b0, "R1", "pi in reset");
    chk(sec_tick, 1'b0, "R1", "sec in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // sweep every rate code over two periods
    for (int c = 0; c < 16; c++) begin
      code = 4'(c);
      restart();
      if (c == 0) begin
        for (int i = 0; i < 300; i++) step_chk(1'b1);
      end else begin
        for (int i = 0; i < 2 * (32768 / freq_of(c)) + 3; i++) step_chk(1'b1);
      end
    end

    // R2: irregular tick pattern
    code = 4'd3;
    restart();
    for (int i = 0; i < 90; i++) step_chk((i % 3) != 0);

    // R2: clear held with ticks present
    code = 4'd4;
    for (int i = 0; i < 7; i++) step_chk(1'b1);
    div_clr = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1'b1);
      chk(sqw, 1'b0, "R2", "sqw under clear");
      chk(pi_flag, 1'b0, "R2", "pi under clear");
      chk(sec_tick, 1'b0, "R2", "sec under clear");
    end
    div_clr = 1'b0;
    n = 0;
    for (int i = 0; i < 40; i++) step_chk(1'b1);

    // R8: enable off, then power fail
    code = 4'd3;
    sqw_en = 1'b0;
    for (int i = 0; i < 20; i++) step_chk(1'b1);
    sqw_en = 1'b1;
    pwr_fail = 1'b1;
    for (int i = 0; i < 20; i++) step_chk(1'b1);
    pwr_fail = 1'b0;
    for (int i = 0; i < 20; i++) step_chk(1'b1);

    // R9: periodic enable off
    pi_en = 1'b0;
    for (int i = 0; i < 40; i++) step_chk(1'b1);
    pi_en = 1'b1;

    // R10: second tick with the selector off
    code = 4'd0;
    restart();
    for (int i = 0; i < 32770; i++) step_chk(1'b1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule